// File: doc/BRIEF.md
# Self-Synchronising PRBS Stream Checker

This block checks a parallel received stream against one of five pseudo-random binary sequences (PRBS7, PRBS9, PRBS15, PRBS23, PRBS31, each defined by the polynomial 1 + x^a + x^b). It never needs a seed shared with the transmitter. The first enabled word after reset is loaded straight into a history register and is not compared. After that, every expected bit comes from bits already received: expected s[n] = s[n-a] XOR s[n-b]. As a result the checker locks on its own and recovers by itself after a corrupted bit.

Three behaviours shape what the block reports:

- **Error masking.** Mismatches are ignored for a programmable number of words after lock, so that link settling is not reported.
- **Error stretching.** A reported mismatch drives an error flag that stays high long enough for a slower clock domain to capture it.
- **Done flag.** A sticky flag rises once one full sequence period of bits has been checked.

A single clear input drops both flags. A clock-enable input freezes the whole checker.

Top module: `prbs_chk`

## Requirements
- R1: Pattern select `pat_sel_i`/`pat31_i` decodes as follows: 0001 gives PRBS7 (taps 6,7), 0010 gives PRBS9 (5,9), 0100 gives PRBS15 (14,15), 1000 gives PRBS23 (18,23), and 0000 with `pat31_i`=1 gives PRBS31 (28,31). Expected bit s[n] = s[n-a] XOR s[n-b].
- R2: Width selection works as follows:
  - When `narrow_i`=1 and PRBS9 is selected, each word is the 10 bits `data_i[9:0]` and bits 63:10 are ignored.
  - In every other case the word is all 64 bits.
  - Bit 0 is always the earliest bit in time.
- R3: The first enabled word after reset only loads the history and is never compared. Every later bit is predicted from previously received bits, including earlier bits of the same word.
- R4: A reported mismatch in a word drives `err_o` high from the next cycle. `err_o` stays high for exactly 8 enabled cycles after the last reported word, and a new report restarts that count.
- R5: The mask window depends on `mask_sel_i`: 00 = 128, 01 = 256, 10 = 512, 11 = 1024 words. Mismatches in compared words 0 to window-1 after lock are not reported. The word counter saturates at 1024.
- R6: `done_o` rises in the cycle after the number of bits compared since reset or the last clear reaches 2^b - 1. It stays high until cleared.
- R7: `err_clr_i` clears `err_o`, `done_o` and the compared-bit count at the next edge, regardless of `en_i`, and takes priority over a new report in the same cycle.
- R8: With `en_i`=0 the history, word counters, bit count and stretch count all hold, so `err_o` and `done_o` keep their values (unless clear is applied).
- R9: Any other pattern code leaves the checker idle: nothing is loaded or compared, and no new error is reported.
- R10: During and right after reset `err_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; 0 freezes the checker |
| pat_sel_i | input | 4 | One-hot pattern select |
| pat31_i | input | 1 | Selects PRBS31 when `pat_sel_i` is 0000 |
| narrow_i | input | 1 | 10-bit word mode (PRBS9 only) |
| mask_sel_i | input | 2 | Initial mask window select |
| err_clr_i | input | 1 | Clears error and done flags |
| data_i | input | 64 | Received word, bit 0 earliest |
| err_o | output | 1 | Stretched error flag |
| done_o | output | 1 | Sticky full-period-checked flag |

## Verification
The following are checked by properties on every cycle:

- the sticky done flag and its dependence on a compared word;
- the effect of clear and of a disabled enable;
- reporting of an unmasked mismatch, and silence for a masked one;
- the idle behaviour under an illegal pattern code;
- the minimum stretch length of the error flag.

Only the bench scenarios can show that the prediction is correct for each polynomial and for both word widths, including the spill of a single corrupted bit into the next word. The scenarios also show the exact cycle in which done rises for each period, the exact 8-cycle stretch with restart, and that the upper data bits are ignored in 10-bit mode.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int HIST_W = 31;
  localparam int N_PAT  = 5;

  typedef enum logic [2:0] {PAT_NONE, PAT_7, PAT_9, PAT_15, PAT_23, PAT_31} pat_e;

  function automatic int tap_a(int k);
    case (k)
      0: return 6;
      1: return 5;
      2: return 14;
      3: return 18;
      default: return 28;
    endcase
  endfunction

  function automatic int tap_b(int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 15;
      3: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic logic [31:0] period_of(pat_e p);
    case (p)
      PAT_7:   return 32'd127;
      PAT_9:   return 32'd511;
      PAT_15:  return 32'd32767;
      PAT_23:  return 32'd8388607;
      PAT_31:  return 32'h7fff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/prbs_chk_decode.sv
module prbs_chk_decode
  import prbs_chk_pkg::*;
(
  input  logic [3:0]  pat_sel_i,
  input  logic        pat31_i,
  input  logic        narrow_i,
  output pat_e        pat_o,
  output logic        valid_o,
  output logic        narrow_o,
  output logic [31:0] period_o
);
  always_comb begin
    case (pat_sel_i)
      4'b0001: pat_o = PAT_7;
      4'b0010: pat_o = PAT_9;
      4'b0100: pat_o = PAT_15;
      4'b1000: pat_o = PAT_23;
      4'b0000: pat_o = pat31_i ? PAT_31 : PAT_NONE;
      default: pat_o = PAT_NONE;
    endcase
  end

  assign valid_o  = (pat_o != PAT_NONE);
  assign narrow_o = narrow_i && (pat_o == PAT_9);
  assign period_o = period_of(pat_o);
endmodule

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 10
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HIST_W-1:0] hist_i,
  input  pat_e              pat_i,
  input  logic              narrow_i,
  output logic              mism_o,
  output logic [HIST_W-1:0] hist_o
);
  localparam int EXT_W = DATA_W + HIST_W;

  logic [EXT_W-1:0]              ext;
  logic [N_PAT-1:0][DATA_W-1:0]  cand;
  logic [DATA_W-1:0]             expect_w;
  logic [DATA_W-1:0]             lane_mask;

  assign ext = {data_i, hist_i};

  for (genvar k = 0; k < N_PAT; k++) begin : g_pat
    localparam int TA = tap_a(k);
    localparam int TB = tap_b(k);
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      assign cand[k][j] = ext[HIST_W+j-TA] ^ ext[HIST_W+j-TB];
    end
  end

  always_comb begin
    case (pat_i)
      PAT_7:   expect_w = cand[0];
      PAT_9:   expect_w = cand[1];
      PAT_15:  expect_w = cand[2];
      PAT_23:  expect_w = cand[3];
      PAT_31:  expect_w = cand[4];
      default: expect_w = data_i;
    endcase
  end

  assign lane_mask = narrow_i ? {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}} : '1;
  assign mism_o    = |((expect_w ^ data_i) & lane_mask);
  assign hist_o    = narrow_i ? ext[NARROW_W+HIST_W-1:NARROW_W] : ext[EXT_W-1:DATA_W];
endmodule

// File: rtl/prbs_chk_status.sv
module prbs_chk_status #(
  parameter int STRETCH   = 8,
  parameter int MASK_BASE = 128,
  parameter int MASK_W    = $clog2(MASK_BASE*8+1),
  parameter int STEP_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              cmp_i,
  input  logic              mism_i,
  input  logic [1:0]        mask_sel_i,
  input  logic [31:0]       period_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              err_o,
  output logic              done_o,
  output logic [MASK_W-1:0] mask_cnt_o,
  output logic [MASK_W-1:0] window_o
);
  localparam int ST_W = $clog2(STRETCH+1);
  localparam logic [MASK_W-1:0] MASK_MAX = MASK_W'(MASK_BASE*8);

  logic [MASK_W-1:0] mask_q;
  logic [31:0]       bits_q, bits_d;
  logic [32:0]       sum;
  logic [ST_W-1:0]   st_q;
  logic              done_q, rpt, hit;

  assign window_o   = MASK_W'(MASK_BASE) << mask_sel_i;
  assign mask_cnt_o = mask_q;
  assign rpt        = cmp_i && mism_i && (mask_q >= window_o);
  assign sum        = {1'b0, bits_q} + 33'(step_i);
  assign bits_d     = sum[32] ? '1 : sum[31:0];
  assign hit        = sum >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    mask_q <= '0;
    else if (en_i && cmp_i && (mask_q != MASK_MAX)) mask_q <= mask_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      done_q <= 1'b0;
      st_q   <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
      done_q <= 1'b0;
      st_q   <= '0;
    end else if (en_i) begin
      if (cmp_i) begin
        bits_q <= bits_d;
        if (hit) done_q <= 1'b1;
      end
      if (rpt)              st_q <= ST_W'(STRETCH);
      else if (st_q != '0)  st_q <= st_q - 1'b1;
    end
  end

  assign err_o  = (st_q != '0);
  assign done_o = done_q;
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NARROW_W  = 10,
  parameter int STRETCH   = 8,
  parameter int MASK_BASE = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        pat_sel_i,
  input  logic              pat31_i,
  input  logic              narrow_i,
  input  logic [1:0]        mask_sel_i,
  input  logic              err_clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              err_o,
  output logic              done_o
);
  localparam int MASK_W = $clog2(MASK_BASE*8+1);
  localparam int STEP_W = $clog2(DATA_W+1);

  pat_e              pat;
  logic              cfg_ok, narrow, mism, upd, cmp, seeded_q;
  logic [31:0]       period;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [STEP_W-1:0] step;
  logic [MASK_W-1:0] mask_cnt, window;

  prbs_chk_decode u_dec (
    .pat_sel_i (pat_sel_i),
    .pat31_i   (pat31_i),
    .narrow_i  (narrow_i),
    .pat_o     (pat),
    .valid_o   (cfg_ok),
    .narrow_o  (narrow),
    .period_o  (period)
  );

  prbs_chk_predict #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pred (
    .data_i   (data_i),
    .hist_i   (hist_q),
    .pat_i    (pat),
    .narrow_i (narrow),
    .mism_o   (mism),
    .hist_o   (hist_d)
  );

  assign upd  = en_i && cfg_ok;
  assign cmp  = upd && seeded_q;
  assign step = narrow ? STEP_W'(NARROW_W) : STEP_W'(DATA_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      hist_q   <= '0;
    end else if (upd) begin
      seeded_q <= 1'b1;
      hist_q   <= hist_d;
    end
  end

  prbs_chk_status #(
    .STRETCH(STRETCH), .MASK_BASE(MASK_BASE), .MASK_W(MASK_W), .STEP_W(STEP_W)
  ) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .clr_i      (err_clr_i),
    .cmp_i      (cmp),
    .mism_i     (mism),
    .mask_sel_i (mask_sel_i),
    .period_i   (period),
    .step_i     (step),
    .err_o      (err_o),
    .done_o     (done_o),
    .mask_cnt_o (mask_cnt),
    .window_o   (window)
  );
endmodule

// File: rtl/prbs_chk_sva.sv
module prbs_chk_sva #(
  parameter int STRETCH = 8,
  parameter int MASK_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              err_clr_i,
  input logic              err_o,
  input logic              done_o,
  input logic              cmp,
  input logic              mism,
  input logic              cfg_ok,
  input logic [MASK_W-1:0] mask_cnt,
  input logic [MASK_W-1:0] window
);
  logic [7:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hi_q <= '0;
    else if (!err_o)         hi_q <= '0;
    else if (hi_q != 8'hff)  hi_q <= hi_q + 1'b1;
  end

  p_stretch_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) && !$past(err_clr_i) |-> hi_q >= 8'(STRETCH));

  p_report_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp && mism && !err_clr_i && (mask_cnt >= window) |=> err_o);

  p_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp && mism && (mask_cnt < window) && !err_o && !err_clr_i |=> !err_o);

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_clr_i |=> done_o);

  p_done_needs_cmp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !cmp |=> !done_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> !err_o && !done_o);

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !err_clr_i |=> $stable(err_o) && $stable(done_o));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok && !err_o |=> !err_o);
endmodule

bind prbs_chk prbs_chk_sva #(.STRETCH(STRETCH), .MASK_W(MASK_W)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .err_clr_i (err_clr_i),
  .err_o     (err_o),
  .done_o    (done_o),
  .cmp       (cmp),
  .mism      (mism),
  .cfg_ok    (cfg_ok),
  .mask_cnt  (mask_cnt),
  .window    (window)
);

// File: tb/sim_prbs_chk.sv
`timescale 1ns/1ps
module sim_prbs_chk;
  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, clr = 1'b0, pat31 = 1'b0, narrow = 1'b0;
  logic [3:0]  psel = '0;
  logic [1:0]  msel = '0;
  logic [63:0] data = '0;
  logic        err, done;

  always #4 clk = ~clk;

  prbs_chk u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .pat_sel_i(psel), .pat31_i(pat31),
    .narrow_i(narrow), .mask_sel_i(msel), .err_clr_i(clr), .data_i(data),
    .err_o(err), .done_o(done)
  );

  int vec = 0, bad = 0;
  string req = "R10";
  int ta, tb, w, win;
  bit valid;
  longint period;
  bit g[$];
  bit q[$];
  bit m_seed, m_done;
  int m_mcnt, m_scnt;
  longint m_bcnt;

  task automatic chk(string what, logic act, logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit gbit();
    bit nb = g[g.size()-ta] ^ g[g.size()-tb];
    g.push_back(nb);
    void'(g.pop_front());
    return nb;
  endfunction

  task automatic setup(logic [3:0] ps, logic p31, logic nr, logic [1:0] ms, string r);
    psel = ps; pat31 = p31; narrow = nr; msel = ms;
    valid = 1'b1;
    case (ps)
      4'b0001: begin ta = 6;  tb = 7;  end
      4'b0010: begin ta = 5;  tb = 9;  end
      4'b0100: begin ta = 14; tb = 15; end
      4'b1000: begin ta = 18; tb = 23; end
      4'b0000: if (p31) begin ta = 28; tb = 31; end else valid = 1'b0;
      default: valid = 1'b0;
    endcase
    if (!valid) begin ta = 6; tb = 7; end
    period = (64'd1 << tb) - 1;
    w   = (nr && ps == 4'b0010) ? 10 : 64;
    win = 128 << ms;
    g.delete(); repeat (40) g.push_back(1'b1);
    q.delete(); repeat (40) q.push_back(1'b0);
    m_seed = 0; m_done = 0; m_mcnt = 0; m_scnt = 0; m_bcnt = 0;
    en = 0; clr = 0; data = '0;
    rst_ni = 1'b0;
    req = "R10";
    repeat (2) @(negedge clk);
    chk("err_o in reset", err, 1'b0);
    chk("done_o in reset", done, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("err_o after reset", err, 1'b0);
    chk("done_o after reset", done, 1'b0);
    req = r;
  endtask

  task automatic cycle(logic [63:0] d, bit e, bit c);
    bit cmp, mism, rep, eb;
    data = d; en = e; clr = c;
    cmp = e && valid && m_seed;
    mism = 0; rep = 0;
    if (e && valid) begin
      for (int j = 0; j < w; j++) begin
        if (cmp) begin
          eb = q[q.size()-ta] ^ q[q.size()-tb];
          if (eb != d[j]) mism = 1;
        end
        q.push_back(d[j]);
        void'(q.pop_front());
      end
      if (cmp) begin
        rep = mism && (m_mcnt >= win);
        if (m_mcnt < 1024) m_mcnt++;
      end
      m_seed = 1;
    end
    if (c) begin
      m_bcnt = 0; m_done = 0; m_scnt = 0;
    end else if (e) begin
      if (cmp) begin
        m_bcnt += w;
        if (m_bcnt >= period) m_done = 1;
      end
      if (rep) m_scnt = 8;
      else if (m_scnt > 0) m_scnt--;
    end
    @(posedge clk);
    #2;
    chk("err_o", err, m_scnt != 0);
    chk("done_o", done, m_done);
    @(negedge clk);
  endtask

  task automatic words(int n, int inj, int clr_at);
    for (int i = 0; i < n; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      for (int j = 0; j < w; j++) d[j] = gbit();
      if (i == inj) d[3] = ~d[3];
      cycle(d, 1'b1, i == clr_at);
    end
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    // PRBS7 64-bit, mask 128: done, masked and reported errors
    setup(4'b0001, 1'b0, 1'b0, 2'b00, "R1 R3 R5 R6");
    words(61, 60, -1);
    words(100, -1, -1);
    req = "R4 R5";
    words(10, 5, -1);
    req = "R4";
    words(20, 2, -1);
    words(20, 3, -1);
    words(4, 0, -1);
    req = "R7";
    words(4, -1, 0);
    words(4, -1, -1);
    req = "R4 R8";
    words(1, 0, -1);
    for (int i = 0; i < 6; i++) cycle({$urandom, $urandom}, 1'b0, 1'b0);
    req = "R7 R8";
    cycle({$urandom, $urandom}, 1'b0, 1'b1);
    cycle({$urandom, $urandom}, 1'b0, 1'b0);
    req = "R3 R6";
    words(20, -1, -1);

    // PRBS9 10-bit, mask 256
    setup(4'b0010, 1'b0, 1'b1, 2'b01, "R2 R5 R6");
    words(101, 100, -1);
    words(200, 180, -1);
    words(20, -1, -1);

    // PRBS15 64-bit, mask 512
    setup(4'b0100, 1'b0, 1'b0, 2'b10, "R1 R5 R6");
    words(600, 530, -1);
    words(20, -1, -1);

    // PRBS23 64-bit
    setup(4'b1000, 1'b0, 1'b0, 2'b00, "R1");
    words(200, 150, -1);

    // PRBS31 64-bit
    setup(4'b0000, 1'b1, 1'b0, 2'b00, "R1");
    words(200, 140, -1);

    // mask 1024
    setup(4'b0001, 1'b0, 1'b0, 2'b11, "R5");
    words(701, 700, -1);
    words(420, 400, -1);

    // narrow ignored outside PRBS9
    setup(4'b0001, 1'b0, 1'b1, 2'b00, "R2");
    words(160, 140, -1);

    // illegal codes stay idle
    setup(4'b0011, 1'b0, 1'b0, 2'b00, "R9");
    words(200, 150, -1);
    setup(4'b0000, 1'b0, 1'b0, 2'b00, "R9");
    words(200, 160, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule